// File: doc/BRIEF.md
# Periodic Interrupt Timer Bank

This block is a bank of independent 32-bit down-counters behind a small register bus. Software writes a start value into a channel and switches the channel on. The counter then counts down once per clock. When it reaches zero it raises a sticky flag and reloads from its start value, so it keeps producing events at a fixed rate until software turns it off. Each channel has its own interrupt line, gated by that channel's interrupt enable. A single combined line reports whether any channel is requesting service.

A module-wide off switch holds every counter. It is set when the block leaves reset. An odd-numbered channel can be switched so that it counts the expiry events of the channel just below it. The pair then forms one 64-bit counter, in which the upper channel expiring marks a full 64-bit wrap. Rewriting a start value does not disturb a period already in progress. To restart the count at once, software turns the channel off and then on again.

Top module: `periodic_tmr_bank`

## Requirements
- R1: After reset the module control word reads 0x2 (off switch set). Every channel's start value, count, control and flag read 0, and all interrupt outputs are low.
- R2: While the module control bit 1 (off switch) is 1, no channel's count changes except by an enable load.
- R3: Writing control bit 0 (run) from 0 to 1 copies the start value into the count on that write edge. The count then steps down once per cycle. The cycle after it reads 0 it reloads from the start value and sets flag bit 0. An expiry therefore occurs every start value + 1 cycles and repeats without software action.
- R4: Writing the start value while a channel runs leaves the running count untouched. The new value is used from the next reload.
- R5: Writing the flag word with bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R6: Writes to the count word are ignored.
- R7: `irq_ch_o[n]` is channel n's flag ANDed with its control bit 1 (interrupt enable). `irq_any_o` is the OR of all `irq_ch_o` bits.
- R8: An odd channel with control bit 2 (chain) set steps only in cycles where the channel below it expires. It expires itself when it reads 0 in such a cycle.
- R9: Register map, word aligned. Module control is at 0x000. Channel n starts at 0x100 + 0x10·n, with the start value at +0x0, the count at +0x4, the control word at +0x8 and the flag at +0xC. Control bits: 0 run, 1 interrupt enable, 2 chain. Reads return in `rdata_o` on the clock edge that samples `rd_en_i`, and unmapped addresses read 0.
- R10: A channel whose run bit is 0 holds its count. Switching it on again reloads the count from the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_ch_o | output | 4 | Per-channel interrupt requests |
| irq_any_o | output | 1 | OR of all channel requests |

## Verification
A run-bit write at edge E0 places the start value L in the count at E0. The flag and any enabled interrupt appear at edge E0+L+1, and a read issued in the cycle after edge Ek returns L−k. The bench counts edges from each write's own edge and samples on the falling edge. It checks that the interrupt is still low one cycle before its due edge and high right after it. The same edge counting sets the due cycles for mid-period start-value rewrites, where the old period finishes first and the new one follows at the rewritten length, and for a chained pair, where the upper channel's event lands on the lower channel's second expiry after a start of 1.

// File: rtl/tmr_pkg.sv
// Package tmr_pkg
// Shared widths, register offsets and the channel control layout.
// Assumes word-aligned accesses and at most 16 channels.
package tmr_pkg;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned MAX_CH    = 16;
    // register index inside a channel window (address bits 3:2)
    localparam logic [1:0] REG_START  = 2'd0;
    localparam logic [1:0] REG_COUNT  = 2'd1;
    localparam logic [1:0] REG_CTL    = 2'd2;
    localparam logic [1:0] REG_FLAG   = 2'd3;
    localparam int unsigned CTL_W     = 3;

    typedef struct packed {
        logic chain;   // bit 2
        logic irq_en;  // bit 1
        logic run;     // bit 0
    } chan_ctl_t;
endpackage

// File: rtl/tmr_chan.sv
// Module tmr_chan
// One down-counting channel: start register, count, control and sticky flag.
// Assumes only one register strobe is active per cycle.
// CAN_CHAIN selects whether the chain bit makes it step on tick_i.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int unsigned CW        = 32,
    parameter bit          CAN_CHAIN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mod_off_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          start_we_i,
    input  logic          ctl_we_i,
    input  logic          flag_we_i,
    input  logic          tick_i,
    output logic [CW-1:0] start_q_o,
    output logic [CW-1:0] count_o,
    output chan_ctl_t     ctl_o,
    output logic          flag_o,
    output logic          expire_o,
    output logic          irq_o
);
    logic step;
    logic load_now;
    logic tick_ok;
    logic clr_req;

    // chained odd channels advance only on the lower channel's expiry
    generate
        if (CAN_CHAIN) begin : g_chain
            assign tick_ok = ctl_o.chain ? tick_i : 1'b1;
        end else begin : g_free
            assign tick_ok = 1'b1 | tick_i;
        end
    endgenerate

    // decide whether this cycle loads, steps or expires
    always_comb begin
        load_now = ctl_we_i && wdata_i[0] && !ctl_o.run;
        step     = ctl_o.run && !mod_off_i && tick_ok;
        expire_o = step && (count_o == '0);
        clr_req  = flag_we_i && wdata_i[0];
        irq_o    = flag_o && ctl_o.irq_en;
    end

    // start value and control word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q_o <= '0;
            ctl_o     <= '0;
        end else begin
            if (start_we_i) start_q_o <= wdata_i;
            if (ctl_we_i)   ctl_o     <= chan_ctl_t'(wdata_i[CTL_W-1:0]);
        end
    end

    // down counter with load on enable and reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (load_now) begin
            count_o <= start_q_o;
        end else if (expire_o) begin
            count_o <= start_q_o;
        end else if (step) begin
            count_o <= count_o - 1'b1;
        end
    end

    // sticky flag, set wins over write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_o <= 1'b0;
        else if (expire_o) flag_o <= 1'b1;
        else if (clr_req)  flag_o <= 1'b0;
    end

    a_r3_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> flag_o);
    a_r3_reload_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> count_o == $past(start_q_o));
    a_r2_module_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_off_i && !load_now) |=> $stable(count_o));
    a_r5_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire_o) |=> !flag_o);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_req) |=> flag_o);
    a_r4_start_write_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we_i && step && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o.run && !load_now) |=> $stable(count_o));

    generate
        if (CAN_CHAIN) begin : g_chain_chk
            a_r8_chain_waits: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_o.chain && !tick_i && !load_now) |=> $stable(count_o));
        end
    endgenerate
endmodule

// File: rtl/tmr_irq_or.sv
// Module tmr_irq_or
// Merges the per-channel requests into one line.
// Assumes the requests are already registered.
module tmr_irq_or #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req_i,
    output logic         any_o
);
    // reduction of all channel requests
    always_comb any_o = |req_i;
endmodule

// File: rtl/periodic_tmr_bank.sv
// Module periodic_tmr_bank
// Register decode, module off switch, channel array and read mux.
// Assumes ADDR_W of 12, word-aligned accesses and NUM_CH at most 16.
// Odd channels may chain to the channel below them.
module periodic_tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CW     = DATA_W,
    parameter int unsigned AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [CW-1:0]     wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [CW-1:0]     rdata_o,
    output logic [NUM_CH-1:0] irq_ch_o,
    output logic              irq_any_o
);
    localparam int unsigned PAGE_W = AW - 8;

    logic              mod_off;
    logic              aligned;
    logic              mcr_hit;
    logic              page_hit;
    logic [3:0]        ch_idx;
    logic [1:0]        reg_idx;
    logic [CW-1:0]     rd_mux;
    logic [CW-1:0]     start_arr [NUM_CH];
    logic [CW-1:0]     count_arr [NUM_CH];
    chan_ctl_t         ctl_arr   [NUM_CH];
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] exp_vec;

    // address decode
    always_comb begin
        aligned  = (addr_i[1:0] == 2'b00);
        mcr_hit  = aligned && (addr_i == '0);
        page_hit = aligned && (addr_i[AW-1:8] == PAGE_W'(1));
        ch_idx   = addr_i[7:4];
        reg_idx  = addr_i[3:2];
    end

    // module off switch, set out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)                  mod_off <= 1'b1;
        else if (wr_en_i && mcr_hit) mod_off <= wdata_i[1];
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam bit ODD = (i % 2) == 1;
            logic sel;
            logic tick;
            assign sel = wr_en_i && page_hit && (ch_idx == 4'(i));
            if (ODD) begin : g_link
                assign tick = exp_vec[i-1];
            end else begin : g_nolink
                assign tick = 1'b0;
            end
            tmr_chan #(.CW(CW), .CAN_CHAIN(ODD)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .mod_off_i  (mod_off),
                .wdata_i    (wdata_i),
                .start_we_i (sel && reg_idx == REG_START),
                .ctl_we_i   (sel && reg_idx == REG_CTL),
                .flag_we_i  (sel && reg_idx == REG_FLAG),
                .tick_i     (tick),
                .start_q_o  (start_arr[i]),
                .count_o    (count_arr[i]),
                .ctl_o      (ctl_arr[i]),
                .flag_o     (flag_vec[i]),
                .expire_o   (exp_vec[i]),
                .irq_o      (irq_ch_o[i])
            );
        end
    endgenerate

    tmr_irq_or #(.N(NUM_CH)) u_irq_or (
        .req_i (irq_ch_o),
        .any_o (irq_any_o)
    );

    // read mux over module and channel registers
    always_comb begin
        rd_mux = '0;
        if (mcr_hit) begin
            rd_mux[1] = mod_off;
        end else if (page_hit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == 4'(i)) begin
                    case (reg_idx)
                        REG_START: rd_mux = start_arr[i];
                        REG_COUNT: rd_mux = count_arr[i];
                        REG_CTL:   rd_mux = {{(CW-CTL_W){1'b0}}, ctl_arr[i]};
                        default:   rd_mux = {{(CW-1){1'b0}}, flag_vec[i]};
                    endcase
                end
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

    a_r7_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o == (irq_ch_o != '0));
    a_r1_off_after_reset: assert property (@(posedge clk)
        !rst_n |=> mod_off);
endmodule

// File: tb/periodic_tmr_bank_tb_top.sv
module periodic_tmr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq_ch;
    logic        irq_any;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    periodic_tmr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .irq_ch_o(irq_ch), .irq_any_o(irq_any)
    );

    function automatic logic [11:0] ra(int ch, int off);
        return 12'(32'h100 + 32'h10 * ch + off);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // drive at falling edge, return at the falling edge after the write edge
    task automatic wr(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, v); chk("R1 module control", v, 32'h2);
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 16; o += 4) begin
                rd(ra(c, o), v); chk("R1 channel reg", v, 0);
            end
        end
        chk("R1 irq lines", {27'b0, irq_any, irq_ch}, 0);

        // R2 off switch blocks counting even when run is set
        wr(ra(0, 0), 32'd5);
        wr(ra(0, 8), 32'd1);
        rd(ra(0, 4), v); chk("R2 count while off", v, 32'd5);
        rd(ra(0, 4), v); chk("R2 count while off again", v, 32'd5);
        wr(ra(0, 8), 32'd0);
        wr(12'h000, 32'd0);

        // R9 register readback and unmapped read
        wr(ra(1, 0), 32'hDEADBEEF);
        rd(ra(1, 0), v); chk("R9 start readback", v, 32'hDEADBEEF);
        wr(ra(1, 8), 32'd6);
        rd(ra(1, 8), v); chk("R9 control readback", v, 32'd6);
        wr(ra(1, 8), 32'd0);
        rd(12'h080, v); chk("R9 unmapped reads zero", v, 0);

        // R3 R7 period sweep over every channel and small start values
        for (int c = 0; c < 4; c++) begin
            for (int l = 1; l <= 5; l++) begin
                wr(ra(c, 0), 32'(l));
                wr(ra(c, 8), 32'd3);
                repeat (l) @(negedge clk);
                chk("R3 no early expiry", {28'b0, irq_ch}, 0);
                @(negedge clk);
                chk("R3 R7 expiry on time", {28'b0, irq_ch}, 32'(1 << c));
                chk("R7 combined line", {31'b0, irq_any}, 1);
                repeat (l + 1) @(negedge clk);
                chk("R3 repeats", {28'b0, irq_ch}, 32'(1 << c));
                wr(ra(c, 8), 32'd0);
                wr(ra(c, 12), 32'd1);
                chk("R5 clear drops irq", {31'b0, irq_any}, 0);
            end
        end

        // R4 start write mid-period does not restart
        wr(ra(2, 0), 32'd10);
        wr(ra(2, 8), 32'd3);
        wr(ra(2, 0), 32'd3);
        rd(ra(2, 4), v); chk("R4 count kept", v, 32'd9);
        repeat (8) @(negedge clk);
        chk("R4 old period still running", {31'b0, irq_ch[2]}, 0);
        @(negedge clk);
        chk("R4 old period ends", {31'b0, irq_ch[2]}, 1);
        wr(ra(2, 12), 32'd1);
        chk("R5 cleared", {31'b0, irq_ch[2]}, 0);
        repeat (2) @(negedge clk);
        chk("R4 new period not yet", {31'b0, irq_ch[2]}, 0);
        @(negedge clk);
        chk("R4 new period used", {31'b0, irq_ch[2]}, 1);
        wr(ra(2, 8), 32'd0);
        wr(ra(2, 12), 32'd1);

        // R2 off switch freezes a running counter, R10 idle hold, R6 read-only count
        wr(ra(3, 0), 32'd1000);
        wr(ra(3, 8), 32'd1);
        wr(12'h000, 32'd2);
        rd(ra(3, 4), v);
        rd(ra(3, 4), v2); chk("R2 frozen by off switch", v2, v);
        wr(12'h000, 32'd0);
        rd(ra(3, 4), v);
        rd(ra(3, 4), v2); chk("R2 resumes", v2, v - 1);
        wr(ra(3, 8), 32'd0);
        rd(ra(3, 4), v);
        rd(ra(3, 4), v2); chk("R10 idle hold", v2, v);
        wr(ra(3, 4), 32'h55);
        rd(ra(3, 4), v2); chk("R6 count write ignored", v2, v);
        wr(ra(3, 8), 32'd1);
        rd(ra(3, 4), v); chk("R10 reload on enable", v, 32'd1000);
        wr(ra(3, 8), 32'd0);

        // R8 chained pair
        wr(ra(0, 0), 32'd2);
        wr(ra(1, 0), 32'd1);
        wr(ra(1, 8), 32'd7);
        wr(ra(0, 8), 32'd1);
        rd(ra(1, 4), v); chk("R8 upper waits", v, 32'd1);
        repeat (4) @(negedge clk);
        chk("R8 no early rollover", {31'b0, irq_ch[1]}, 0);
        @(negedge clk);
        chk("R8 rollover on second lower expiry", {31'b0, irq_ch[1]}, 1);
        chk("R7 lower irq masked", {31'b0, irq_ch[0]}, 0);
        wr(ra(0, 8), 32'd0);
        wr(ra(1, 8), 32'd0);

        // R5 write zero keeps flag, write one clears
        rd(ra(0, 12), v); chk("R5 lower flag set", v, 1);
        wr(ra(0, 12), 32'd0);
        rd(ra(0, 12), v); chk("R5 write zero ignored", v, 1);
        wr(ra(0, 12), 32'hFFFF_FFFE);
        rd(ra(0, 12), v); chk("R5 bit0 clear ignored", v, 1);
        wr(ra(0, 12), 32'd1);
        rd(ra(0, 12), v); chk("R5 write one clears", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule